// File: doc/BRIEF.md
# BCD Repeated-Add Score Accumulator

This block keeps a running game score in decimal form so that it can drive a three-digit display with no binary-to-decimal conversion. The score is held as two full 4-bit BCD digits (units and tens) and a 2-bit hundreds digit. The hundreds digit is narrow because a complete game never reaches 400.

A controller multiplies a throw's pin count by holding the add-enable high for that many clock cycles. The pin count (0 to 10) is added once on every rising clock edge while the enable is high. When the enable is low, the score is held. Each addition corrects the decimal digits: a digit sum above nine is adjusted by six and carries into the next digit. The carry into the hundreds digit is a plain binary increment. The active-low reset is the only way to clear the score.

Top module: `bcd_score_acc`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all three output digits read zero.
- R2: On each rising clock edge with `add_en` high, the decimal value shown by the digits grows by the value on `pins`. Holding `add_en` high for k edges with a steady `pins` adds k times `pins`.
- R3: On an edge with `add_en` low, the digits keep their value whatever `pins` carries.
- R4: A units sum above nine leaves the units digit at that sum minus ten and carries one into tens. Adding 10 to a units digit of 9 gives units 9 with a carry (for example, 9 plus 10 reads 0,1,9).
- R5: A carry into a tens digit of 9 leaves tens at 0 and increments hundreds (for example, 99 plus 1 reads 1,0,0).
- R6: `digit_units` and `digit_tens` never exceed 9. The two upper bits of `digit_hund` are always zero.
- R7: A total of 300 is represented exactly, as hundreds 3, tens 0 and units 0 (a game of twelve strikes).
- R8: Driven with the enable-pulse lengths of a scored game whose throws are 0,10 | 6,1 | 4,5 | 0,6 | 6,4 | 10 | 0,0 | 10 | 3,5 | 10 followed by fill throws 8 and 2, the final reading is 114.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous clear of the score |
| add_en | input | 1 | Add `pins` to the score on each edge while high |
| pins | input | 4 | Pin count to add, 0 to 10 |
| digit_hund | output | 4 | Hundreds digit, zero-extended from 2 bits |
| digit_tens | output | 4 | Tens digit, BCD |
| digit_units | output | 4 | Units digit, BCD |

## Verification
The hardest case to reach is a double ripple: a units carry that arrives while tens already reads 9. For the hundreds digit to increment, the units digit must first be pushed close to nine and the tens digit must sit at exactly nine. Directed stimulus builds 99 from repeated adds of 9 and then adds one. It also adds 10 to a units digit of 9. Complete games, including a perfect game, drive the long multi-cycle enable pulses that a scorer produces. Random pulses of random pin counts and random lengths then step the total through many carry patterns, and the bench compares every reading with a decimal model.

// File: rtl/bcd_score_pkg.sv
package bcd_score_pkg;

    localparam int DIGIT_W   = 4;
    localparam int FULL_DIGS = 2;
    localparam int HUND_W    = 2;
    localparam int PIN_W     = 4;
    localparam int DISP_W    = 4;

    typedef struct packed {
        logic [HUND_W-1:0]                  hund;
        logic [FULL_DIGS-1:0][DIGIT_W-1:0]  low;
    } score_t;

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
    parameter int DIGIT_W = 4,
    parameter int ADD_W   = 4
) (
    input  logic [DIGIT_W-1:0] digit_in,
    input  logic [ADD_W-1:0]   addend,
    output logic [DIGIT_W-1:0] digit_out,
    output logic               carry_out
);

    localparam int SUM_W = ((DIGIT_W > ADD_W) ? DIGIT_W : ADD_W) + 1;

    logic [SUM_W-1:0] raw_sum;
    logic             over_nine;

    always_comb begin
        raw_sum   = SUM_W'(digit_in) + SUM_W'(addend);
        over_nine = (raw_sum > SUM_W'(9));
        if (over_nine) begin
            digit_out = raw_sum[DIGIT_W-1:0] + DIGIT_W'(6);
        end else begin
            digit_out = raw_sum[DIGIT_W-1:0];
        end
        carry_out = over_nine;
    end

    // R6
    always_comb begin
        if ((digit_in <= DIGIT_W'(9)) && (addend <= ADD_W'(10))) begin
            digit_range_chk: assert (digit_out <= DIGIT_W'(9));
        end
    end

endmodule

// File: rtl/bcd_score_acc.sv
module bcd_score_acc
    import bcd_score_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [PIN_W-1:0]  pins,
    output logic [DISP_W-1:0] digit_hund,
    output logic [DISP_W-1:0] digit_tens,
    output logic [DISP_W-1:0] digit_units
);

    score_t acc_d, acc_q;

    logic [FULL_DIGS-1:0][DIGIT_W-1:0] dsum;
    logic [FULL_DIGS-1:0]              dcarry;

    for (genvar gi = 0; gi < FULL_DIGS; gi++) begin : g_digit
        logic [PIN_W-1:0] addend;
        if (gi == 0) begin : g_first
            assign addend = pins;
        end else begin : g_rest
            assign addend = PIN_W'(dcarry[gi-1]);
        end
        bcd_digit_add #(
            .DIGIT_W (DIGIT_W),
            .ADD_W   (PIN_W)
        ) u_digit (
            .digit_in  (acc_q.low[gi]),
            .addend    (addend),
            .digit_out (dsum[gi]),
            .carry_out (dcarry[gi])
        );
    end

    always_comb begin
        acc_d = acc_q;
        if (add_en) begin
            acc_d.low  = dsum;
            acc_d.hund = acc_q.hund + HUND_W'(dcarry[FULL_DIGS-1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign digit_units = acc_q.low[0];
    assign digit_tens  = acc_q.low[1];
    assign digit_hund  = DISP_W'(acc_q.hund);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(acc_q));

    // R2
    add_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && (pins != '0)) |=> (acc_q != $past(acc_q)));

    // R4
    units_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && ((5'(acc_q.low[0]) + 5'(pins)) > 5'd9) && (acc_q.low[1] != 4'd9))
        |=> (acc_q.low[1] == $past(acc_q.low[1]) + 4'd1));

    // R5
    tens_ripple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && dcarry[0] && (acc_q.low[1] == 4'd9))
        |=> ((acc_q.low[1] == 4'd0) && (acc_q.hund == $past(acc_q.hund) + 2'd1)));

    // R6
    digits_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.low[0] <= 4'd9) && (acc_q.low[1] <= 4'd9));

endmodule

// File: tb/bcd_score_acc_tb.sv
module bcd_score_acc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       add_en = 1'b0;
    logic [3:0] pins = 4'd0;
    logic [3:0] digit_hund, digit_tens, digit_units;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bcd_score_acc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .add_en      (add_en),
        .pins        (pins),
        .digit_hund  (digit_hund),
        .digit_tens  (digit_tens),
        .digit_units (digit_units)
    );

    function automatic int shown();
        return int'(digit_hund) * 100 + int'(digit_tens) * 10 + int'(digit_units);
    endfunction

    task automatic check_val(input string req, input int expected);
        checks++;
        if (shown() != expected || digit_hund > 4'd3 || digit_tens > 4'd9 || digit_units > 4'd9) begin
            errors++;
            $display("FAIL %s: actual=%0d/%0d/%0d expected=%0d", req,
                     digit_hund, digit_tens, digit_units, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; add_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = 0;
    endtask

    task automatic pulse(input int p, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            add_en = 1'b1; pins = 4'(p);
        end
        @(negedge clk);
        add_en = 1'b0;
        model = (model + p * len) % 400;
    endtask

    // frame-based scorer: returns total, sets count of regular throws
    function automatic int frame_score(input int t[], output int nreg);
        int idx = 0;
        int s = 0;
        for (int f = 0; f < 10; f++) begin
            if (t[idx] == 10) begin
                s += 10 + t[idx+1] + t[idx+2]; idx += 1;
            end else if (t[idx] + t[idx+1] == 10) begin
                s += 10 + t[idx+2]; idx += 2;
            end else begin
                s += t[idx] + t[idx+1]; idx += 2;
            end
        end
        nreg = idx;
        return s;
    endfunction

    task automatic play_game(input string req, input int t[]);
        int nreg, expect_total;
        int s0 = 0, s1 = 0, sp = 0, prev = 0;
        bit first = 1'b1;
        expect_total = frame_score(t, nreg);
        do_reset();
        for (int k = 0; k < t.size(); k++) begin
            int mult, ns, nsp;
            mult = s0 + s1 + sp + ((k < nreg) ? 1 : 0);
            pulse(t[k], mult);
            ns = 0; nsp = 0;
            if (k < nreg) begin
                if (first) begin
                    ns = (t[k] == 10) ? 1 : 0;
                    prev = t[k];
                    first = (t[k] == 10);
                end else begin
                    nsp = (prev + t[k] == 10) ? 1 : 0;
                    first = 1'b1;
                end
            end
            s0 = s1; s1 = ns; sp = nsp;
        end
        check_val(req, expect_total);
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        @(negedge clk);
        check_val("R1 in reset", 0);
        do_reset();
        check_val("R1 after reset", 0);

        pulse(9, 1);
        check_val("R2 single add", 9);
        pulse(10, 1);
        check_val("R4 9+10", 19);

        do_reset();
        pulse(9, 11);
        check_val("R2 eleven adds", 99);
        pulse(1, 1);
        check_val("R5 99+1", 100);

        // R3: idle cycles with changing pins
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            pins = 4'(i * 2 + 1);
        end
        @(negedge clk);
        check_val("R3 hold", 100);

        pulse(10, 3);
        check_val("R2 three adds of 10", 130);

        do_reset();
        check_val("R1 reset clears", 0);

        play_game("R8 game", '{0,10, 6,1, 4,5, 0,6, 6,4, 10, 0,0, 10, 3,5, 10, 8,2});
        checks++;
        if (shown() != 114) begin
            errors++;
            $display("FAIL R8: actual=%0d expected=114", shown());
        end
        play_game("R7 perfect", '{10,10,10,10,10,10,10,10,10,10,10,10});
        checks++;
        if (digit_hund != 4'd3 || digit_tens != 4'd0 || digit_units != 4'd0) begin
            errors++;
            $display("FAIL R7: actual=%0d/%0d/%0d expected=3/0/0",
                     digit_hund, digit_tens, digit_units);
        end

        do_reset();
        for (int n = 0; n < 300; n++) begin
            int p, len;
            p   = int'($urandom_range(10, 0));
            len = int'($urandom_range(3, 0));
            if (model + p * len > 390) do_reset();
            pulse(p, len);
            check_val("R2 R6 random", model);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule